// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards against runaway software. A down-counter, reloaded to its all-ones value by each service write, steps once per tick. The tick comes either from a prescaler on the bus clock or from rising edges of a free-running on-chip oscillator clock. If software stops writing the service strobe, the counter passes zero and the block raises a fault.

The fault action depends on a mode bit. With the bit clear, the block gives a one-cycle interrupt pulse and reloads the counter, so the interrupt repeats for as long as servicing is missing. With the bit set, the block raises a reset request and holds it until the system reset arrives. Software can set the mode bit but cannot clear it.

The prescaler ratio follows the bus clock source. A sub-clock source always divides by 2. Other sources divide by 16 or by 128, chosen by a ratio bit. After reset, nothing counts until the first service write. Stop and wait modes freeze the counter and the prescaler in place.

Top module: `wdt_core`

## Requirements
- R1: After reset `wdt_irq` and `wdt_rst_req` are 0, and no fault occurs before the first `svc_wr` pulse, however long the block waits.
- R2: With `src_sub`=0, `div_sel`=0 and `osc_sel`=0, one count takes 16 bus clocks. A fault comes 16·2^CNT_W cycles after the service write, measured from a reset-cleared prescaler.
- R3: With `src_sub`=0, `div_sel`=1 and `osc_sel`=0, one count takes 128 bus clocks. The fault period is 128·2^CNT_W cycles.
- R4: With `src_sub`=1 and `osc_sel`=0, the prescaler divides by 2 whatever `div_sel` holds. The fault period is 2·2^CNT_W cycles.
- R5: With `osc_sel`=1, the counter steps once per rising edge of `osc_clk`. Faults then repeat every 2^CNT_W oscillator rising edges.
- R6: With the mode bit at 0, an underflow gives a `wdt_irq` pulse exactly one cycle wide. The counter reloads on that underflow, so interrupts repeat at the full period.
- R7: Each `svc_wr` pulse reloads the counter to all ones. Service writes spaced closer than the period prevent every fault.
- R8: A write with `mode_wr`=1 and `mode_din`=1 sets the mode bit. A later write of 0 leaves it set, so the next underflow raises `wdt_rst_req` and gives no `wdt_irq`.
- R9: Once raised, `wdt_rst_req` stays at 1 until `rst_n` goes low. That reset also clears the mode bit, so the next underflow gives an interrupt.
- R10: While `stop_mode` or `wait_mode` is 1, the counter and the prescaler hold their values. The fault is delayed by exactly the number of frozen cycles.
- R11: If `svc_wr` falls in the same cycle as an underflow, the counter reloads and no fault is raised. The next fault comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset |
| src_sub | input | 1 | 1 when the bus clock comes from the sub clock |
| div_sel | input | 1 | Ratio select for other sources: 0 gives /16, 1 gives /128 |
| osc_sel | input | 1 | 1 steps the counter from `osc_clk` edges instead of the prescaler |
| osc_clk | input | 1 | On-chip oscillator clock, sampled in the bus clock domain |
| svc_wr | input | 1 | Service-register write strobe |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_din | input | 1 | Value written to the mode bit (1 selects reset action) |
| stop_mode | input | 1 | Stop mode active, freezes counting |
| wait_mode | input | 1 | Wait mode active, freezes counting |
| wdt_irq | output | 1 | One-cycle interrupt request on underflow |
| wdt_rst_req | output | 1 | Held reset request on underflow in reset mode |

## Verification
A service write and a counter underflow can land on the same clock edge. The bench first times one interrupt, so it knows the exact cycle of the next underflow. It then drives `svc_wr` for that one edge. The outcome is correct only if no interrupt follows that edge and the next interrupt comes one full period later, which shows that the reload took priority.

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W   = 15,
  parameter int SUB_LOG = 1,
  parameter int LO_LOG  = 4,
  parameter int HI_LOG  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sub,
  input  logic div_sel,
  input  logic osc_sel,
  input  logic osc_clk,
  input  logic svc_wr,
  input  logic mode_wr,
  input  logic mode_din,
  input  logic stop_mode,
  input  logic wait_mode,
  output logic wdt_irq,
  output logic wdt_rst_req
);

  localparam int PRE_W = HI_LOG;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PRE_W-1:0] M_SUB = PRE_W'((1 << SUB_LOG) - 1);
  localparam logic [PRE_W-1:0] M_LO  = PRE_W'((1 << LO_LOG) - 1);
  localparam logic [PRE_W-1:0] M_HI  = PRE_W'((1 << HI_LOG) - 1);

  logic             running;
  logic             mode;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [2:0]       osc_sy;

  logic             active;
  logic [PRE_W-1:0] pre_mask;
  logic             div_tick;
  logic             osc_rise;
  logic             tick;
  logic             uf;
  logic             fault;

  assign active   = running & ~(stop_mode | wait_mode);
  assign pre_mask = src_sub ? M_SUB : (div_sel ? M_HI : M_LO);
  assign div_tick = (pre & pre_mask) == pre_mask;
  assign osc_rise = osc_sy[1] & ~osc_sy[2];
  assign tick     = active & (osc_sel ? osc_rise : div_tick);
  assign uf       = tick & (cnt == '0);
  assign fault    = uf & ~svc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running     <= 1'b0;
      mode        <= 1'b0;
      cnt         <= CNT_MAX;
      pre         <= '0;
      osc_sy      <= '0;
      wdt_irq     <= 1'b0;
      wdt_rst_req <= 1'b0;
    end else begin
      osc_sy <= {osc_sy[1:0], osc_clk};
      if (svc_wr)
        running <= 1'b1;
      if (mode_wr && mode_din)
        mode <= 1'b1;
      if (active)
        pre <= pre + 1'b1;
      if (svc_wr || uf)
        cnt <= CNT_MAX;
      else if (tick)
        cnt <= cnt - 1'b1;
      wdt_irq <= fault & ~mode;
      if (fault && mode)
        wdt_rst_req <= 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!wdt_irq && !wdt_rst_req));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |=> !wdt_irq);

  // R7
  svc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_wr |=> (cnt == CNT_MAX));

  // R8
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> mode);

  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> wdt_rst_req);

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_mode || wait_mode) && !svc_wr) |=> ($stable(cnt) && $stable(pre)));

endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
  localparam int W = 8;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sub = 0, div_sel = 0, osc_sel = 0, osc_clk = 0;
  logic svc_wr = 0, mode_wr = 0, mode_din = 0, stop_mode = 0, wait_mode = 0;
  logic wdt_irq, wdt_rst_req;

  int checks = 0;
  int errors = 0;
  int osc_div = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    osc_div <= (osc_div == 2) ? 0 : osc_div + 1;
    if (osc_div == 2) osc_clk <= ~osc_clk;
  end

  wdt_core #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_sub(src_sub), .div_sel(div_sel),
    .osc_sel(osc_sel), .osc_clk(osc_clk), .svc_wr(svc_wr), .mode_wr(mode_wr),
    .mode_din(mode_din), .stop_mode(stop_mode), .wait_mode(wait_mode),
    .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    {src_sub, div_sel, osc_sel, svc_wr, mode_wr, mode_din, stop_mode, wait_mode} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic count_until(input bit use_rst, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (use_rst ? wdt_rst_req : wdt_irq) break;
    end
  endtask

  task automatic svc_then_count(input bit use_rst, input int limit, output int n);
    int m;
    svc_wr = 1;
    @(posedge clk);
    @(negedge clk);
    svc_wr = 0;
    count_until(use_rst, limit, m);
    n = m + 1;
  endtask

  task automatic t_reset_state();
    int n;
    do_reset();
    chk(!wdt_irq && !wdt_rst_req, "R1 outputs after reset", {wdt_irq, wdt_rst_req}, 0);
    count_until(0, 5000, n);
    chk(n == 5000 && !wdt_rst_req, "R1 no fault before first service", n, 5000);
  endtask

  task automatic t_period(input bit sub, input bit dsel, input int ratio, input string tag);
    int n;
    do_reset();
    src_sub = sub;
    div_sel = dsel;
    svc_then_count(0, ratio * N + 100, n);
    chk(n == ratio * N + 1, tag, n, ratio * N + 1);
  endtask

  task automatic t_irq_repeat();
    int n;
    do_reset();
    svc_then_count(0, 16 * N + 100, n);
    @(negedge clk);
    chk(!wdt_irq, "R6 interrupt one cycle wide", wdt_irq, 0);
    count_until(0, 16 * N + 100, n);
    chk(n + 1 == 16 * N, "R6 interrupt repeats at full period", n + 1, 16 * N);
  endtask

  task automatic t_osc();
    int n;
    do_reset();
    osc_sel = 1;
    div_sel = 1;
    svc_then_count(0, 6 * N + 200, n);
    count_until(0, 6 * N + 200, n);
    chk(n == 6 * N, "R5 oscillator edge period", n, 6 * N);
  endtask

  task automatic t_service();
    int seen = 0;
    do_reset();
    for (int k = 0; k < 5; k++) begin
      svc_wr = 1;
      @(negedge clk);
      svc_wr = 0;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if (wdt_irq || wdt_rst_req) seen++;
      end
    end
    chk(seen == 0, "R7 regular servicing prevents faults", seen, 0);
  endtask

  task automatic t_freeze(input bit use_stop, input string tag);
    int n;
    do_reset();
    svc_then_count(0, 16 * N + 100, n);
    repeat (100) @(negedge clk);
    if (use_stop) stop_mode = 1; else wait_mode = 1;
    repeat (500) @(negedge clk);
    chk(!wdt_irq, tag, wdt_irq, 0);
    stop_mode = 0;
    wait_mode = 0;
    count_until(0, 16 * N + 1000, n);
    chk(n + 600 == 16 * N + 500, tag, n + 600, 16 * N + 500);
  endtask

  task automatic t_collide();
    int n;
    do_reset();
    svc_then_count(0, 16 * N + 100, n);
    repeat (16 * N - 1) @(negedge clk);
    svc_wr = 1;
    @(negedge clk);
    svc_wr = 0;
    chk(!wdt_irq && !wdt_rst_req, "R11 service wins over underflow", wdt_irq, 0);
    count_until(0, 16 * N + 100, n);
    chk(n == 16 * N, "R11 next fault one period later", n, 16 * N);
  endtask

  task automatic t_sticky();
    int n;
    int irqs = 0;
    do_reset();
    mode_wr = 1; mode_din = 1;
    @(negedge clk);
    mode_din = 0;
    @(negedge clk);
    mode_wr = 0;
    svc_then_count(1, 16 * N + 100, n);
    chk(n == 16 * N + 1, "R8 reset request after clear attempt", n, 16 * N + 1);
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (wdt_irq) irqs++;
      if (!wdt_rst_req) irqs += 1000;
    end
    chk(irqs == 0, "R9 reset request held, no interrupt", irqs, 0);
    do_reset();
    chk(!wdt_rst_req, "R9 reset clears request", wdt_rst_req, 0);
    svc_then_count(0, 16 * N + 100, n);
    chk(n == 16 * N + 1 && !wdt_rst_req, "R9 mode cleared by reset", n, 16 * N + 1);
  endtask

  initial begin
    t_reset_state();
    t_period(0, 0, 16, "R2 divide by 16 period");
    t_period(0, 1, 128, "R3 divide by 128 period");
    t_period(1, 1, 2, "R4 sub clock ignores ratio bit");
    t_period(1, 0, 2, "R4 sub clock divide by 2");
    t_irq_repeat();
    t_osc();
    t_service();
    t_freeze(0, "R10 wait mode freeze");
    t_freeze(1, "R10 stop mode freeze");
    t_collide();
    t_sticky();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule